// File: doc/BRIEF.md
# Opcode-Selected Add, Subtract and Nibble-Multiply Unit

This block is a small arithmetic unit for a datapath that needs three operations on a pair of byte operands without separate adders for each. A 2-bit operation code picks one of four results: the byte sum of the operands, their byte difference, the unsigned product of their low nibbles, or a constant zero for the unused code. Sum and difference come out of a single ripple chain of full-adder cells. A per-bit XOR stage inverts the second operand when subtracting, and the same control bit feeds the chain as its first carry-in. The product comes from a regular array of AND-gate partial products that are reduced row by row with half- and full-adder cells.

All arithmetic is combinational. The chosen result is captured in an output register on each rising clock edge, so a result appears one cycle after its operands are presented. A synchronous active-high reset clears that register. No flags are produced. Carries and overflow beyond the result width are dropped, so sums and differences wrap modulo 2^W.

Top module: `opsel_arith_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `result_o` becomes zero, whatever the operands and operation code.
- R2: `result_o` reflects the operands and operation code sampled at the previous rising edge, and holds steady between edges.
- R3: Operation code 2'b00 gives (`a_i` + `b_i`) modulo 256.
- R4: Operation code 2'b01 gives (`a_i` − `b_i`) modulo 256, i.e. `a_i` plus the two's complement of `b_i`; for example 0 − 1 gives 8'hFF.
- R5: Operation code 2'b10 gives the unsigned product `a_i[3:0]` × `b_i[3:0]` as an 8-bit value; 15 × 15 gives 8'hE1.
- R6: Under operation code 2'b10, bits [7:4] of both operands have no effect on the result.
- R7: Operation code 2'b11 gives 8'h00 for any operands.
- R8: The carry out of the top bit is discarded: 8'hFF + 8'h01 gives 8'h00, and a subtraction with no borrow, such as 8'h05 − 8'h05, gives 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register captures on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_i | input | 2 | Operation code: 00 add, 01 subtract, 10 nibble multiply, 11 zero |
| a_i | input | W (8) | First operand (minuend, multiplicand in the low nibble) |
| b_i | input | W (8) | Second operand (subtrahend, multiplier in the low nibble) |
| result_o | output | W (8) | Registered result of the selected operation |

## Verification
The hardest part to observe from the ports is whether the multiplier really ignores the upper operand nibbles. A product that happens to be right with zero upper bits tells nothing about leakage from bits [7:4]. The bench therefore sweeps every one of the 256 low-nibble pairs with random values in the upper nibbles, and it repeats the 15 × 15 corner with the upper bits all ones. The carry-discard behaviour of the shared chain only shows up at the wrap points, so 255 + 1, A = B subtraction and A < B subtraction are driven on purpose alongside random operand pairs.

// File: rtl/opsel_arith_pkg.sv
package opsel_arith_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_MUL  = 2'b10,
    OP_ZERO = 2'b11
  } arith_op_e;
endpackage

// File: rtl/arith_cells.sv
// One-bit adder cells shared by the add/subtract chain and the multiplier array.
module arith_full_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic ci_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = x_i ^ y_i ^ ci_i;
  assign co_o = (x_i & y_i) | (ci_i & (x_i ^ y_i));
endmodule

module arith_half_cell (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = x_i ^ y_i;
  assign co_o = x_i & y_i;
endmodule

// File: rtl/ripple_addsub.sv
// W-bit ripple chain; sub_i inverts the second operand and seeds the carry.
// The top stage computes only its sum bit, so the carry out is dropped.
module ripple_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] y_cond;
  logic [W-1:0] carry;

  assign carry[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_cond[i] = y_i[i] ^ sub_i;
    if (i < W - 1) begin : g_mid
      arith_full_cell u_fa (
        .x_i  (x_i[i]),
        .y_i  (y_cond[i]),
        .ci_i (carry[i]),
        .s_o  (sum_o[i]),
        .co_o (carry[i+1])
      );
    end else begin : g_top
      assign sum_o[i] = x_i[i] ^ y_cond[i] ^ carry[i];
    end
  end
endmodule

// File: rtl/array_mult.sv
// N x N unsigned array multiplier: AND partial products, reduced one row
// at a time by a ripple row (half cell at the low end, full cells above).
module array_mult #(
  parameter int N = 4
) (
  input  logic [N-1:0]   x_i,
  input  logic [N-1:0]   y_i,
  output logic [2*N-1:0] p_o
);
  logic [N-1:0] pp  [N];
  logic [N-1:0] acc [N];
  logic         cy  [N];

  for (genvar r = 0; r < N; r++) begin : g_pp
    for (genvar c = 0; c < N; c++) begin : g_and
      assign pp[r][c] = x_i[c] & y_i[r];
    end
  end

  assign acc[0] = pp[0];
  assign cy[0]  = 1'b0;
  assign p_o[0] = acc[0][0];

  for (genvar r = 1; r < N; r++) begin : g_row
    logic [N-1:0] xin;
    logic [N-1:0] rc;
    assign xin = {cy[r-1], acc[r-1][N-1:1]};

    arith_half_cell u_ha (
      .x_i  (xin[0]),
      .y_i  (pp[r][0]),
      .s_o  (acc[r][0]),
      .co_o (rc[0])
    );
    for (genvar k = 1; k < N; k++) begin : g_fa
      arith_full_cell u_fa (
        .x_i  (xin[k]),
        .y_i  (pp[r][k]),
        .ci_i (rc[k-1]),
        .s_o  (acc[r][k]),
        .co_o (rc[k])
      );
    end
    assign cy[r]  = rc[N-1];
    assign p_o[r] = acc[r][0];
  end

  assign p_o[2*N-1:N] = {cy[N-1], acc[N-1][N-1:1]};
endmodule

// File: rtl/opsel_arith_unit.sv
module opsel_arith_unit #(
  parameter int W  = 8,
  parameter int MW = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o
);
  import opsel_arith_pkg::*;

  localparam int PW = 2 * MW;

  arith_op_e    op;
  logic [W-1:0] as_res;
  logic [PW-1:0] prod;
  logic [W-1:0] prod_ext;
  logic [W-1:0] next_res;

  assign op = arith_op_e'(op_i);

  ripple_addsub #(.W(W)) u_addsub (
    .x_i   (a_i),
    .y_i   (b_i),
    .sub_i (op == OP_SUB),
    .sum_o (as_res)
  );

  array_mult #(.N(MW)) u_mult (
    .x_i (a_i[MW-1:0]),
    .y_i (b_i[MW-1:0]),
    .p_o (prod)
  );

  assign prod_ext = W'(prod);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: next_res = as_res;
      OP_MUL:         next_res = prod_ext;
      default:        next_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= next_res;
  end
endmodule

// File: rtl/opsel_arith_chk.sv
module opsel_arith_chk #(
  parameter int W  = 8,
  parameter int MW = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> result_o == '0);

  p_add_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    op_i == 2'b00 |=> result_o == W'($past(a_i) + $past(b_i)));

  p_sub_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    op_i == 2'b01 |=> result_o == W'($past(a_i) - $past(b_i)));

  p_mul_nibble_r5: assert property (@(posedge clk) disable iff (rst)
    op_i == 2'b10 |=> result_o ==
      (W'($past(a_i[MW-1:0])) * W'($past(b_i[MW-1:0]))));

  p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
    op_i == 2'b11 |=> result_o == '0);

  p_hold_inputs_r2: assert property (@(posedge clk) disable iff (rst)
    ($stable(op_i) && $stable(a_i) && $stable(b_i) && !$past(rst))
      |=> $stable(result_o));
endmodule

bind opsel_arith_unit opsel_arith_chk #(.W(W), .MW(MW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .result_o (result_o)
);

// File: tb/opsel_arith_unit_tb.sv
`timescale 1ns/1ps
module opsel_arith_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op  = 2'b00;
  logic [7:0] a   = 8'h00;
  logic [7:0] b   = 8'h00;
  logic [7:0] res;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  opsel_arith_unit #(.W(8), .MW(4)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op),
    .a_i      (a),
    .b_i      (b),
    .result_o (res)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: op=%b a=%h b=%h got %h expected %h", req, op, a, b, act, exp);
    end
  endtask

  // Present operands at a falling edge, check one full cycle later.
  task automatic apply(input string req, input logic [1:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic [7:0] exp);
    @(negedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    check(req, res, exp);
  endtask

  task automatic t_reset;
    rst = 1'b1; op = 2'b00; a = 8'h5A; b = 8'h33;
    repeat (3) @(negedge clk);
    check("R1", res, 8'h00);
    op = 2'b10; a = 8'h0F; b = 8'h0F;
    @(negedge clk);
    check("R1", res, 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    apply("R2", 2'b00, 8'h10, 8'h20, 8'h30);
    op = 2'b00; a = 8'h01; b = 8'h01;
    #1 check("R2", res, 8'h30);
    @(negedge clk);
    check("R2", res, 8'h02);
    @(negedge clk);
    check("R2", res, 8'h02);
  endtask

  task automatic t_add;
    logic [7:0] x, y;
    apply("R3", 2'b00, 8'h00, 8'h00, 8'h00);
    apply("R3", 2'b00, 8'h7F, 8'h01, 8'h80);
    for (int i = 0; i < 200; i++) begin
      x = 8'($urandom); y = 8'($urandom);
      apply("R3", 2'b00, x, y, 8'(x + y));
    end
  endtask

  task automatic t_sub;
    logic [7:0] x, y;
    apply("R4", 2'b01, 8'h00, 8'h01, 8'hFF);
    apply("R4", 2'b01, 8'h03, 8'hF0, 8'h13);
    apply("R4", 2'b01, 8'hFF, 8'h00, 8'hFF);
    apply("R4", 2'b01, 8'h00, 8'hFF, 8'h01);
    for (int i = 0; i < 200; i++) begin
      x = 8'($urandom); y = 8'($urandom);
      apply("R4", 2'b01, x, y, 8'(x - y));
    end
  endtask

  task automatic t_wrap;
    apply("R8", 2'b00, 8'hFF, 8'h01, 8'h00);
    apply("R8", 2'b00, 8'hFF, 8'hFF, 8'hFE);
    apply("R8", 2'b01, 8'h05, 8'h05, 8'h00);
    apply("R8", 2'b01, 8'hA7, 8'hA7, 8'h00);
  endtask

  task automatic t_mul;
    logic [3:0] hx, hy;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        hx = 4'($urandom); hy = 4'($urandom);
        apply("R5", 2'b10, {hx, 4'(i)}, {hy, 4'(j)}, 8'(i * j));
      end
    end
    apply("R5", 2'b10, 8'h0F, 8'h0F, 8'hE1);
  endtask

  task automatic t_mul_high;
    apply("R6", 2'b10, 8'hFF, 8'hFF, 8'hE1);
    apply("R6", 2'b10, 8'hF0, 8'hF0, 8'h00);
    apply("R6", 2'b10, 8'h93, 8'h65, 8'h0F);
  endtask

  task automatic t_unused;
    apply("R7", 2'b00, 8'h12, 8'h34, 8'h46);
    apply("R7", 2'b11, 8'hFF, 8'hFF, 8'h00);
    apply("R7", 2'b11, 8'h12, 8'h34, 8'h00);
    apply("R7", 2'b11, 8'h0F, 8'h0F, 8'h00);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_add();
    t_sub();
    t_wrap();
    t_mul();
    t_mul_high();
    t_unused();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule